// File: doc/BRIEF.md
# Standby Entry and Wake Controller

This block is a small state machine that decides when a microcontroller stops its clocks and how it starts them again. The CPU raises a one-cycle sleep strobe. If three configuration bits all agree at that moment, the controller shuts down the oscillator and every clock. It also holds the non-retained peripherals (the serial unit and the PWM units) in reset. If the bits do not agree, the strobe has no effect and the chip keeps running.

The controller has three ways out of standby:

- **Interrupt wake.** An NMI, or an enabled and unmasked IRQ line, restarts the oscillator first. The clocks are released only after a settling wait chosen by a 3-bit code, and then a wake-interrupt request is raised.
- **Reset pin.** Driving the reset pin low turns the oscillator and the clocks on at once. A reset-exception request follows when the pin is released.
- **Hardware standby.** Driving the standby pin low forces a separate hardware-standby state. Only the reset pin can leave it.

The wake lines and the standby pin are sampled through synchronisers. The controller itself runs on a free-running reference clock.

Top module: `stby_ctrl`

## Requirements
- R1: A sleep strobe while running, with the standby-select bit at 1, the low-speed bit at 0 and the watchdog-prescaler bit at 0, moves the block into software standby at the next clock edge. From then on `osc_en` and `clk_en` are 0.
- R2: A sleep strobe while running with any of those three bits in the wrong state leaves `clk_en` and `osc_en` at 1.
- R3: While in software standby, `periph_rst` is 1 and both `osc_en` and `clk_en` are 0. While running, `periph_rst` is 0.
- R4: An NMI wakes the block from software standby regardless of the mask bits. An IRQ line `irq[i]` wakes it only when `irq_en[i]` is 1 and `irq_mask` is 0.
- R5: A wake input that rises between clock edges raises `osc_en` on the third following edge. `clk_en` then stays 0 for exactly N cycles, where N is set by `settle_sel`:

  | `settle_sel` | N (cycles) |
  |---|---|
  | 0 | 8192 |
  | 1 | 16384 |
  | 2 | 32768 |
  | 3 | 65536 |
  | 4 | 131072 |
  | 5 | 262144 |
  | 6 | 1024 |
  | 7 | 2048 |

- R6: `wake_irq` is high for exactly one cycle: the first cycle in which `clk_en` is 1 after an interrupt wake.
- R7: While `res_n` is low, `osc_en` and `clk_en` are 1 regardless of the state the block was in. `rst_exc` is high for exactly the first cycle after `res_n` returns high.
- R8: A low level on `stby_n` puts the block in hardware standby on the third edge after the pin falls, whether it is running or in software standby. There `hstby` is 1 and `osc_en` and `clk_en` are 0. The standby pin wins over a wake interrupt that arrives in the same cycle. The state is kept after `stby_n` returns high, even if an NMI is present, until `res_n` goes low.
- R9: A wake input that is high for fewer than two consecutive clock samples does not wake the block. One that is high for two samples does.
- R10: During reset, `clk_en` and `osc_en` are 1, and `periph_rst`, `hstby`, `wake_irq` and `rst_exc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| res_n | input | 1 | Reset pin, active low, asynchronous |
| stby_n | input | 1 | Hardware-standby pin, active low |
| sleep_stb | input | 1 | One-cycle sleep strobe from the CPU |
| cfg_stby_sel | input | 1 | Standby-select bit, must be 1 to enter |
| cfg_lowspd_on | input | 1 | Low-speed bit, must be 0 to enter |
| cfg_wdt_presel | input | 1 | Watchdog prescaler bit, must be 0 to enter |
| settle_sel | input | 3 | Settling-time code |
| nmi | input | 1 | Non-maskable wake request, level |
| irq | input | N_IRQ | Maskable wake requests, level |
| irq_en | input | N_IRQ | Per-line enables |
| irq_mask | input | 1 | CPU mask for all maskable lines |
| osc_en | output | 1 | Oscillator enable |
| clk_en | output | 1 | Chip-wide clock enable |
| periph_rst | output | 1 | Reset for non-retained peripherals |
| wake_irq | output | 1 | Interrupt-exception request after settling |
| rst_exc | output | 1 | Reset-exception request after reset release |
| hstby | output | 1 | Hardware-standby indicator |

## Verification
A hardware-standby request and an interrupt wake can be resolved in the same clock edge. To provoke this, the bench drives `stby_n` low and `nmi` high on the same falling edge while in software standby. Both pass through synchronisers of equal depth, so they reach the state machine together. The outcome is judged by `hstby` rising while `osc_en` stays 0, and by the block staying in hardware standby after the pin is released and until reset.

// File: rtl/stby_ctrl.sv
module stby_ctrl #(
  parameter int N_IRQ       = 6,
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_BASE  = 1024,
  parameter int LONG_BASE   = 8192
) (
  input  logic             clk,
  input  logic             res_n,
  input  logic             stby_n,
  input  logic             sleep_stb,
  input  logic             cfg_stby_sel,
  input  logic             cfg_lowspd_on,
  input  logic             cfg_wdt_presel,
  input  logic [2:0]       settle_sel,
  input  logic             nmi,
  input  logic [N_IRQ-1:0] irq,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             irq_mask,
  output logic             osc_en,
  output logic             clk_en,
  output logic             periph_rst,
  output logic             wake_irq,
  output logic             rst_exc,
  output logic             hstby
);

  localparam int NW      = N_IRQ + 1;
  localparam int MAX_LEN = LONG_BASE * 32;
  localparam int CNT_W   = $clog2(MAX_LEN);

  typedef enum logic [1:0] {S_RUN, S_SSTBY, S_SETTLE, S_HSTBY} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic             boot, wake_q, rst_q;
  logic [NW-1:0]    wake_raw, wake_lvl;
  logic [SYNC_STAGES-1:0] stby_sh;

  function automatic logic [CNT_W-1:0] settle_last(input logic [2:0] code);
    int n;
    if (code[2:1] == 2'b11) n = SHORT_BASE << code[0];
    else                    n = LONG_BASE << code;
    return CNT_W'(n - 1);
  endfunction

  assign wake_raw = {nmi, irq};

  for (genvar g = 0; g < NW; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] sh;
    always_ff @(posedge clk or negedge res_n)
      if (!res_n) sh <= '0;
      else        sh <= {sh[SYNC_STAGES-2:0], wake_raw[g]};
    assign wake_lvl[g] = &sh;
  end

  always_ff @(posedge clk or negedge res_n)
    if (!res_n) stby_sh <= '1;
    else        stby_sh <= {stby_sh[SYNC_STAGES-2:0], stby_n};

  logic hw_req, nmi_lvl, enter_ok, wake_ok;
  logic [N_IRQ-1:0] irq_lvl;

  assign hw_req   = ~stby_sh[SYNC_STAGES-1];
  assign nmi_lvl  = wake_lvl[N_IRQ];
  assign irq_lvl  = wake_lvl[N_IRQ-1:0];
  assign enter_ok = sleep_stb & cfg_stby_sel & ~cfg_lowspd_on & ~cfg_wdt_presel;
  assign wake_ok  = nmi_lvl | ((|(irq_lvl & irq_en)) & ~irq_mask);

  always_ff @(posedge clk or negedge res_n) begin
    if (!res_n) begin
      st     <= S_RUN;
      cnt    <= '0;
      boot   <= 1'b1;
      wake_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      wake_q <= 1'b0;
      rst_q  <= boot;
      boot   <= 1'b0;
      if (hw_req) st <= S_HSTBY;
      else begin
        case (st)
          S_RUN:    if (enter_ok) st <= S_SSTBY;
          S_SSTBY:  if (wake_ok) begin
                      st  <= S_SETTLE;
                      cnt <= settle_last(settle_sel);
                    end
          S_SETTLE: if (cnt == '0) begin
                      st     <= S_RUN;
                      wake_q <= 1'b1;
                    end else cnt <= cnt - 1'b1;
          S_HSTBY:  st <= S_HSTBY;
          default:  st <= S_RUN;
        endcase
      end
    end
  end

  assign osc_en     = (st == S_RUN) || (st == S_SETTLE);
  assign clk_en     = (st == S_RUN);
  assign periph_rst = (st != S_RUN);
  assign hstby      = (st == S_HSTBY);
  assign wake_irq   = wake_q;
  assign rst_exc    = rst_q;

  a_r1_entry_stops_clock: assert property (@(posedge clk) disable iff (!res_n)
    (clk_en && enter_ok) |=> !clk_en);

  a_r2_refused_sleep_runs: assert property (@(posedge clk) disable iff (!res_n)
    (clk_en && sleep_stb && !enter_ok && !hw_req) |=> clk_en);

  a_r4_masked_stays_down: assert property (@(posedge clk) disable iff (!res_n)
    (!osc_en && !hstby && !nmi_lvl && irq_mask && !hw_req) |=> !osc_en);

  a_r5_settle_holds: assert property (@(posedge clk) disable iff (!res_n)
    (osc_en && !clk_en && cnt != '0 && !hw_req) |=> (osc_en && !clk_en));

  a_r6_wake_on_clock_start: assert property (@(posedge clk) disable iff (!res_n)
    wake_irq |-> $rose(clk_en));

  a_r6_wake_single: assert property (@(posedge clk) disable iff (!res_n)
    wake_irq |=> !wake_irq);

  a_r7_rst_exc_single: assert property (@(posedge clk) disable iff (!res_n)
    rst_exc |=> !rst_exc);

  a_r8_hstby_sticky: assert property (@(posedge clk) disable iff (!res_n)
    hstby |=> (hstby && !osc_en));

endmodule

// File: tb/test_stby_ctrl.sv
module test_stby_ctrl;
  localparam int N_IRQ = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic res_n = 1'b0, stby_n = 1'b1, sleep_stb = 1'b0;
  logic cfg_stby_sel = 1'b1, cfg_lowspd_on = 1'b0, cfg_wdt_presel = 1'b0;
  logic [2:0] settle_sel = 3'd7;
  logic nmi = 1'b0, irq_mask = 1'b0;
  logic [N_IRQ-1:0] irq = '0, irq_en = '0;
  logic osc_en, clk_en, periph_rst, wake_irq, rst_exc, hstby;

  int n_chk = 0, n_fail = 0;

  stby_ctrl #(.N_IRQ(N_IRQ)) i_stby_ctrl (
    .clk(clk), .res_n(res_n), .stby_n(stby_n), .sleep_stb(sleep_stb),
    .cfg_stby_sel(cfg_stby_sel), .cfg_lowspd_on(cfg_lowspd_on),
    .cfg_wdt_presel(cfg_wdt_presel), .settle_sel(settle_sel), .nmi(nmi),
    .irq(irq), .irq_en(irq_en), .irq_mask(irq_mask), .osc_en(osc_en),
    .clk_en(clk_en), .periph_rst(periph_rst), .wake_irq(wake_irq),
    .rst_exc(rst_exc), .hstby(hstby));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic enter_standby;
    sleep_stb = 1'b1;
    step(1);
    sleep_stb = 1'b0;
  endtask

  task automatic count_settle(output int n);
    n = 0;
    while (clk_en == 1'b0 && n < 300000) begin
      n++;
      step(1);
    end
  endtask

  task automatic apply_reset;
    res_n = 1'b0;
    step(2);
    chk("R10", "clk_en in reset", int'(clk_en), 1);
    chk("R10", "osc_en in reset", int'(osc_en), 1);
    chk("R10", "periph_rst in reset", int'(periph_rst), 0);
    chk("R10", "hstby in reset", int'(hstby), 0);
    chk("R10", "wake_irq in reset", int'(wake_irq), 0);
    chk("R10", "rst_exc in reset", int'(rst_exc), 0);
    res_n = 1'b1;
    step(1);
    chk("R7", "rst_exc after release", int'(rst_exc), 1);
    step(1);
    chk("R7", "rst_exc one cycle", int'(rst_exc), 0);
  endtask

  task automatic t_refused_sleep;
    cfg_lowspd_on = 1'b1;
    enter_standby();
    chk("R2", "low-speed set", int'(clk_en), 1);
    cfg_lowspd_on = 1'b0; cfg_wdt_presel = 1'b1;
    enter_standby();
    chk("R2", "prescaler set", int'(clk_en), 1);
    cfg_wdt_presel = 1'b0; cfg_stby_sel = 1'b0;
    enter_standby();
    chk("R2", "select clear", int'(osc_en), 1);
    cfg_stby_sel = 1'b1;
  endtask

  task automatic t_entry;
    chk("R3", "periph_rst while running", int'(periph_rst), 0);
    enter_standby();
    chk("R1", "clk_en after entry", int'(clk_en), 0);
    chk("R1", "osc_en after entry", int'(osc_en), 0);
    chk("R3", "periph_rst in standby", int'(periph_rst), 1);
    step(5);
    chk("R3", "clk_en held off", int'(clk_en), 0);
    apply_reset();
  endtask

  task automatic t_nmi_wake(input logic [2:0] code, input int exp_n);
    int n;
    settle_sel = code;
    irq_mask = 1'b1;
    enter_standby();
    nmi = 1'b1;
    step(2);
    chk("R5", "osc_en before sync", int'(osc_en), 0);
    step(1);
    chk("R4", "nmi wakes despite mask", int'(osc_en), 1);
    chk("R5", "clk_en during settle", int'(clk_en), 0);
    count_settle(n);
    chk("R5", $sformatf("settle length code %0d", code), n, exp_n);
    chk("R6", "wake_irq with first clock", int'(wake_irq), 1);
    nmi = 1'b0;
    irq_mask = 1'b0;
    step(1);
    chk("R6", "wake_irq one cycle", int'(wake_irq), 0);
    chk("R3", "periph_rst released", int'(periph_rst), 0);
  endtask

  task automatic t_irq_gating;
    int n;
    settle_sel = 3'd6;
    enter_standby();
    irq[3] = 1'b1;
    step(8);
    chk("R4", "disabled irq no wake", int'(osc_en), 0);
    irq_en[3] = 1'b1; irq_mask = 1'b1;
    step(8);
    chk("R4", "masked irq no wake", int'(osc_en), 0);
    irq_mask = 1'b0;
    step(1);
    chk("R4", "enabled irq wakes", int'(osc_en), 1);
    count_settle(n);
    chk("R5", "settle length irq code 6", n, 1024);
    irq = '0; irq_en = '0;
  endtask

  task automatic t_glitch;
    int n;
    settle_sel = 3'd6;
    irq_en[0] = 1'b1;
    enter_standby();
    irq[0] = 1'b1;
    step(1);
    irq[0] = 1'b0;
    step(6);
    chk("R9", "one-sample pulse ignored", int'(osc_en), 0);
    irq[0] = 1'b1;
    step(2);
    irq[0] = 1'b0;
    step(1);
    chk("R9", "two-sample pulse wakes", int'(osc_en), 1);
    count_settle(n);
    chk("R9", "settle after pulse", n, 1024);
    irq_en = '0;
  endtask

  task automatic t_reset_wake;
    enter_standby();
    res_n = 1'b0;
    #1;
    chk("R7", "osc_en on reset pin", int'(osc_en), 1);
    chk("R7", "clk_en on reset pin", int'(clk_en), 1);
    step(2);
    res_n = 1'b1;
    step(1);
    chk("R7", "rst_exc after wake reset", int'(rst_exc), 1);
    step(1);
    chk("R7", "rst_exc cleared", int'(rst_exc), 0);
    chk("R7", "running after reset", int'(clk_en), 1);
  endtask

  task automatic t_hw_vs_wake;
    enter_standby();
    stby_n = 1'b0; nmi = 1'b1;
    step(2);
    chk("R8", "hstby before sync", int'(hstby), 0);
    step(1);
    chk("R8", "hstby wins over nmi", int'(hstby), 1);
    chk("R8", "osc_en off in hstby", int'(osc_en), 0);
    stby_n = 1'b1;
    step(10);
    chk("R8", "hstby kept", int'(hstby), 1);
    chk("R8", "osc_en kept off", int'(osc_en), 0);
    nmi = 1'b0;
    apply_reset();
    chk("R8", "hstby left by reset", int'(hstby), 0);
    chk("R8", "clocks back after reset", int'(clk_en), 1);
  endtask

  task automatic t_hw_from_run;
    stby_n = 1'b0;
    step(3);
    chk("R8", "hstby from run", int'(hstby), 1);
    chk("R8", "clk_en off from run", int'(clk_en), 0);
    stby_n = 1'b1;
    step(2);
    apply_reset();
  endtask

  initial begin
    step(1);
    apply_reset();
    t_refused_sleep();
    t_entry();
    t_nmi_wake(3'd7, 2048);
    t_nmi_wake(3'd6, 1024);
    t_nmi_wake(3'd0, 8192);
    t_irq_gating();
    t_glitch();
    t_reset_wake();
    t_hw_vs_wake();
    t_hw_from_run();
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    report();
    $finish;
  end
endmodule